// File: doc/BRIEF.md
# Floating-point min/max with clamp

This unit picks the minimum or the maximum of two single-precision operands and then optionally saturates the result to a fixed range. It suits a shader-style arithmetic pipe: each operation carries its own choice of min or max, one of four policies for NaNs and signed zeros, and a clamp code. A valid strobe goes in with the operands, and the registered result comes out one cycle later with its own strobe.

The four policies fall into two groups. The symmetric policies (0 and 1) treat NaNs specially: one discards a lone NaN, the other always yields a NaN. The strict policies (2 and 3) are a plain ordered compare followed by a select. Because the compare is false for NaNs and for a pair of zeros, these two policies depend on operand order. The clamp runs after the selection. Subnormal values go through untouched, and no exception flags are raised.

Top module: `fmm_unit`

## Requirements
- R1: With policy 0, when exactly one operand is a NaN, the result is the other operand.
- R2: With policy 0, when both operands are NaNs, the result is the quiet NaN 0x7FC00000.
- R3: With policy 0 or 1 and no NaN operand, a +0/-0 pair gives +0 (0x00000000) for both min and max.
- R4: With policy 1, any NaN operand gives a NaN result. If both operands are NaN, the pick follows sign-magnitude order of the raw bits: a clear sign ranks above a set sign, and within one sign a larger mantissa ranks further from zero. Max takes the higher-ranked NaN and min takes the lower-ranked one.
- R5: With policy 2, max gives src_a if src_a > src_b and src_b otherwise; min gives src_a if src_a < src_b and src_b otherwise.
- R6: With policy 3, max gives src_b if src_a < src_b and src_a otherwise; min gives src_b if src_a > src_b and src_a otherwise.
- R7: Policies 2 and 3 use an ordered compare in which +0 equals -0 and any compare with a NaN is false, so swapping the operands can change the result.
- R8: clamp_sel values: 0 leaves the value unchanged. 1 turns any value with the sign bit set (including -0) into +0. 2 limits the magnitude to 1.0 (0x3F800000) and keeps the sign. 3 turns a set sign bit into +0 and caps positive values at 1.0.
- R9: The clamp is applied after selection, and a NaN passes through every clamp code unchanged.
- R10: out_vld equals in_vld delayed by one cycle. out_res updates only in cycles where in_vld is high and holds otherwise.
- R11: A synchronous active-high reset clears out_vld.
- R12: For ordinary operands, pick_max=1 yields the larger value and pick_max=0 the smaller, in every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands and controls are valid |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| pick_max | input | 1 | 1 selects max, 0 selects min |
| policy | input | 2 | NaN and signed-zero policy, 0 to 3 |
| clamp_sel | input | 2 | Output clamp code, 0 to 3 |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 32 | Registered result |

## Verification
The hardest cases to reach are the two-NaN decision under policy 1 and the opposite-sign zero pairs under every policy. Uniform random 32-bit operands almost never produce two NaNs together or an exact +0/-0 pair. The random stimulus therefore draws each operand from a weighted pool: signed zeros, infinities, NaNs with random sign and payload, ±1.0, values near 1.0 and subnormals. Directed vectors add the sign-and-mantissa tie-breaks and both operand orders for the strict policies.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  typedef enum logic [1:0] {
    POL_QUIET        = 2'd0,
    POL_NAN_PROP     = 2'd1,
    POL_LEFT_STRICT  = 2'd2,
    POL_RIGHT_STRICT = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    CLP_NONE     = 2'd0,
    CLP_NONNEG   = 2'd1,
    CLP_SYM_UNIT = 2'd2,
    CLP_UNIT     = 2'd3
  } clamp_e;

  typedef struct packed {
    logic nan;
    logic zero;
    logic sign;
  } fclass_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output fclass_t      cls
);

  function automatic fclass_t f_class(input logic [W-1:0] v);
    fclass_t c;
    logic exp_ones;
    logic man_nz;
    exp_ones = &v[W-2:MAN_W];
    man_nz   = |v[MAN_W-1:0];
    c.nan    = exp_ones && man_nz;
    c.zero   = ~|v[W-2:0];
    c.sign   = v[W-1];
    return c;
  endfunction

  assign cls = f_class(val);

endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fclass_t      ca,
  input  fclass_t      cb,
  output logic         ord_lt,
  output logic         ord_gt,
  output logic         raw_gt
);

  // sign-magnitude "x ranks above y" on raw bits
  function automatic logic f_sm_gt(input logic [W-1:0] x, input logic [W-1:0] y);
    if (x[W-1] != y[W-1]) return !x[W-1];
    if (!x[W-1])          return x[W-2:0] > y[W-2:0];
    return x[W-2:0] < y[W-2:0];
  endfunction

  logic comparable;
  assign comparable = !(ca.nan || cb.nan) && !(ca.zero && cb.zero);
  assign ord_lt     = comparable && f_sm_gt(b, a);
  assign ord_gt     = comparable && f_sm_gt(a, b);
  assign raw_gt     = f_sm_gt(a, b);

endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fclass_t      ca,
  input  fclass_t      cb,
  input  logic         lt,
  input  logic         gt,
  input  logic         raw_gt,
  input  logic         sel_max,
  input  policy_e      pol,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic any_nan, both_nan, zero_pair;
  logic [W-1:0] plain_pick;

  assign any_nan   = ca.nan || cb.nan;
  assign both_nan  = ca.nan && cb.nan;
  assign zero_pair = ca.zero && cb.zero && (ca.sign != cb.sign);

  // symmetric path for non-NaN operands
  always_comb begin
    if (zero_pair)    plain_pick = '0;
    else if (sel_max) plain_pick = lt ? b : a;
    else              plain_pick = lt ? a : b;
  end

  always_comb begin
    res = plain_pick;
    case (pol)
      POL_QUIET: begin
        if (both_nan)     res = QNAN;
        else if (ca.nan)  res = b;
        else if (cb.nan)  res = a;
      end
      POL_NAN_PROP: begin
        if (both_nan)     res = (sel_max == raw_gt) ? a : b;
        else if (ca.nan)  res = a;
        else if (cb.nan)  res = b;
      end
      POL_LEFT_STRICT:  res = sel_max ? (gt ? a : b) : (lt ? a : b);
      POL_RIGHT_STRICT: res = sel_max ? (lt ? b : a) : (gt ? b : a);
      default:          res = plain_pick;
    endcase
  end

endmodule

// File: rtl/fmm_clamp.sv
module fmm_clamp
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  input  logic         is_nan,
  input  clamp_e       code,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  function automatic logic [W-1:0] f_clamp(input logic [W-1:0] v, input clamp_e c);
    logic neg, above;
    neg   = v[W-1];
    above = v[W-2:0] > ONE[W-2:0];
    case (c)
      CLP_NONNEG:   return neg ? '0 : v;
      CLP_SYM_UNIT: return above ? {neg, ONE[W-2:0]} : v;
      CLP_UNIT:     return neg ? '0 : (above ? ONE : v);
      default:      return v;
    endcase
  endfunction

  assign res = is_nan ? val : f_clamp(val, code);

endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         pick_max,
  input  logic [1:0]   policy,
  input  logic [1:0]   clamp_sel,
  output logic         out_vld,
  output logic [W-1:0] out_res
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  policy_e pol;
  clamp_e  clp;
  assign pol = policy_e'(policy);
  assign clp = clamp_e'(clamp_sel);

  fclass_t ca, cb, sel_cls, out_cls;
  logic    ord_lt, ord_gt, raw_gt;
  logic [W-1:0] sel_res, clamp_res, res_q;
  logic    vld_q;

  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.val(src_a), .cls(ca));
  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.val(src_b), .cls(cb));

  fmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a(src_a), .b(src_b), .ca(ca), .cb(cb),
    .ord_lt(ord_lt), .ord_gt(ord_gt), .raw_gt(raw_gt)
  );

  fmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_select (
    .a(src_a), .b(src_b), .ca(ca), .cb(cb),
    .lt(ord_lt), .gt(ord_gt), .raw_gt(raw_gt),
    .sel_max(pick_max), .pol(pol), .res(sel_res)
  );

  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_sel (.val(sel_res), .cls(sel_cls));

  fmm_clamp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_clamp (
    .val(sel_res), .is_nan(sel_cls.nan), .code(clp), .res(clamp_res)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_vld;
    if (in_vld) res_q <= clamp_res;
  end

  assign out_vld = vld_q;
  assign out_res = res_q;

  fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_out (.val(res_q), .cls(out_cls));

  p_single_nan_dropped_r1: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pol == POL_QUIET && (ca.nan ^ cb.nan)) |=> !out_cls.nan);

  p_both_nan_canon_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pol == POL_QUIET && ca.nan && cb.nan) |=> (res_q == QNAN));

  p_zero_pair_pos_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !policy[1] && !ca.nan && !cb.nan && ca.zero && cb.zero &&
     (ca.sign != cb.sign) && clp == CLP_NONE) |=> (out_cls.zero && !out_cls.sign));

  p_nan_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pol == POL_NAN_PROP && (ca.nan || cb.nan)) |=> out_cls.nan);

  p_nonneg_clamp_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && clp == CLP_NONNEG && !sel_cls.nan) |=> !out_cls.sign);

  p_unit_clamp_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && clp == CLP_UNIT && !sel_cls.nan) |=> (!out_cls.sign && res_q[W-2:0] <= ONE[W-2:0]));

  p_nan_through_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && sel_cls.nan) |=> (res_q == $past(sel_res)));

  p_vld_delay_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_vld == $past(in_vld)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res_q));

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> !out_vld);

endmodule

// File: tb/fmm_unit_tb.sv
module fmm_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, in_vld, pick_max;
  logic [31:0] src_a, src_b, out_res;
  logic [1:0] policy, clamp_sel;
  logic out_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmm_unit u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .src_a(src_a), .src_b(src_b),
    .pick_max(pick_max), .policy(policy), .clamp_sel(clamp_sel),
    .out_vld(out_vld), .out_res(out_res)
  );

  // ---------- reference model ----------
  function automatic bit t_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit t_zero(input logic [31:0] x);
    return x[30:0] == 0;
  endfunction
  // monotone key: unsigned compare follows sign-magnitude rank
  function automatic logic [31:0] t_key(input logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction
  function automatic bit t_less(input logic [31:0] x, input logic [31:0] y);
    if (t_nan(x) || t_nan(y)) return 0;
    if (t_zero(x) && t_zero(y)) return 0;
    return t_key(x) < t_key(y);
  endfunction

  function automatic logic [31:0] ref_pick(input logic [31:0] a, input logic [31:0] b,
                                           input bit mx, input logic [1:0] md);
    bit na = t_nan(a), nb = t_nan(b);
    if (md == 2'd2) return mx ? (t_less(b, a) ? a : b) : (t_less(a, b) ? a : b);
    if (md == 2'd3) return mx ? (t_less(a, b) ? b : a) : (t_less(b, a) ? b : a);
    if (na && nb) begin
      if (md == 2'd0) return 32'h7FC0_0000;
      if (mx) return (t_key(a) >= t_key(b)) ? a : b;
      return (t_key(a) <= t_key(b)) ? a : b;
    end
    if (na) return (md == 2'd0) ? b : a;
    if (nb) return (md == 2'd0) ? a : b;
    if (t_zero(a) && t_zero(b)) return (a[31] != b[31]) ? 32'h0 : a;
    return mx ? (t_less(a, b) ? b : a) : (t_less(b, a) ? b : a);
  endfunction

  function automatic logic [31:0] ref_clamp(input logic [31:0] v, input logic [1:0] c);
    if (t_nan(v)) return v;
    case (c)
      2'd1: return v[31] ? 32'h0 : v;
      2'd2: return (v[30:0] > 31'h3F80_0000) ? {v[31], 31'h3F80_0000} : v;
      2'd3: return v[31] ? 32'h0 : ((v[30:0] > 31'h3F80_0000) ? 32'h3F80_0000 : v);
      default: return v;
    endcase
  endfunction

  function automatic string ref_tag(input logic [31:0] a, input logic [31:0] b,
                                    input logic [1:0] md, input logic [1:0] c);
    bit na = t_nan(a), nb = t_nan(b);
    if (md == 2'd2) return "R5";
    if (md == 2'd3) return "R6";
    if (md == 2'd0 && na && nb) return "R2";
    if (md == 2'd0 && (na ^ nb)) return "R1";
    if (md == 2'd1 && (na || nb)) return "R4";
    if (t_zero(a) && t_zero(b)) return "R3";
    if (c != 0) return "R8";
    return "R12";
  endfunction

  // ---------- stimulus helpers ----------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input bit mx,
                       input logic [1:0] md, input logic [1:0] c,
                       input logic [31:0] exp, input string tag);
    src_a = a; src_b = b; pick_max = mx; policy = md; clamp_sel = c; in_vld = 1'b1;
    @(negedge clk);
    check({tag, " out_vld"}, {31'h0, out_vld}, 32'h1);
    check(tag, out_res, exp);
  endtask

  task automatic apply_ref(input logic [31:0] a, input logic [31:0] b, input bit mx,
                           input logic [1:0] md, input logic [1:0] c);
    apply(a, b, mx, md, c, ref_clamp(ref_pick(a, b, mx, md), c), ref_tag(a, b, md, c));
  endtask

  function automatic logic [31:0] pool_val();
    logic s = 1'($urandom);
    case ($urandom % 12)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return {s, 31'h7F80_0000};
      3: return {s, 8'hFF, 23'($urandom) | 23'h1};
      4: return {s, 8'hFF, 23'($urandom) | 23'h1};
      5: return {s, 31'h3F80_0000};
      6: return {s, (($urandom % 2) != 0) ? 8'h7F : 8'h7E, 23'($urandom)};
      7: return {s, 8'h00, 23'($urandom)};
      default: return $urandom;
    endcase
  endfunction

  // ---------- main sequence ----------
  initial begin
    logic [31:0] last;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_vld = 1'b0; pick_max = 1'b0; policy = 2'd0; clamp_sel = 2'd0;
    src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check("R11 reset out_vld", {31'h0, out_vld}, 32'h0);
    rst = 1'b0;

    // R1 / R2
    apply(32'h7FC0_0000, 32'h4000_0000, 1, 0, 0, 32'h4000_0000, "R1");
    apply(32'hC040_0000, 32'hFF80_0001, 0, 0, 0, 32'hC040_0000, "R1");
    apply(32'h7F80_0001, 32'hFFC0_0000, 1, 0, 0, 32'h7FC0_0000, "R2");
    // R3
    apply(32'h0000_0000, 32'h8000_0000, 1, 0, 0, 32'h0000_0000, "R3");
    apply(32'h8000_0000, 32'h0000_0000, 0, 1, 0, 32'h0000_0000, "R3");
    // R4
    apply(32'h7FC0_0001, 32'hFFC0_0005, 1, 1, 0, 32'h7FC0_0001, "R4");
    apply(32'h7FC0_0001, 32'hFFC0_0005, 0, 1, 0, 32'hFFC0_0005, "R4");
    apply(32'h7FC0_0009, 32'h7FC0_0002, 0, 1, 0, 32'h7FC0_0002, "R4");
    apply(32'hFF80_0009, 32'hFF80_0001, 1, 1, 0, 32'hFF80_0001, "R4");
    apply(32'h3F80_0000, 32'h7FC0_0000, 1, 1, 0, 32'h7FC0_0000, "R4");
    // R5 / R6 / R7
    apply(32'h0000_0000, 32'h8000_0000, 1, 2, 0, 32'h8000_0000, "R5");
    apply(32'h7FC0_0000, 32'h3F80_0000, 1, 2, 0, 32'h3F80_0000, "R5");
    apply(32'h3F80_0000, 32'h7FC0_0000, 1, 2, 0, 32'h7FC0_0000, "R7");
    apply(32'h0000_0000, 32'h8000_0000, 1, 3, 0, 32'h0000_0000, "R6");
    apply(32'h8000_0000, 32'h0000_0000, 1, 3, 0, 32'h8000_0000, "R6");
    apply(32'h8000_0000, 32'h0000_0000, 0, 2, 0, 32'h0000_0000, "R7");
    apply(32'h0000_0000, 32'h8000_0000, 0, 2, 0, 32'h8000_0000, "R7");
    // R8 / R9
    apply(32'h40A0_0000, 32'h0000_0000, 1, 0, 2, 32'h3F80_0000, "R8");
    apply(32'hC0A0_0000, 32'h0000_0000, 0, 0, 2, 32'hBF80_0000, "R8");
    apply(32'hC000_0000, 32'hC040_0000, 1, 0, 1, 32'h0000_0000, "R8");
    apply(32'h3F00_0000, 32'h4000_0000, 0, 0, 3, 32'h3F00_0000, "R8");
    apply(32'h8000_0000, 32'h8000_0000, 1, 0, 3, 32'h0000_0000, "R8");
    apply(32'hFFC0_0005, 32'h3F00_0000, 0, 1, 3, 32'hFFC0_0005, "R9");
    apply(32'hC000_0000, 32'h4040_0000, 1, 0, 3, 32'h3F80_0000, "R9");
    // R12
    apply(32'h4040_0000, 32'hC000_0000, 0, 3, 0, 32'hC000_0000, "R12");
    apply(32'h4040_0000, 32'h4000_0000, 1, 2, 0, 32'h4040_0000, "R12");

    // R10 hold while idle
    last = out_res;
    in_vld = 1'b0; src_a = 32'h1234_5678; src_b = 32'h0; clamp_sel = 2'd0;
    @(negedge clk);
    check("R10 idle out_vld", {31'h0, out_vld}, 32'h0);
    check("R10 hold", out_res, last);
    @(negedge clk);
    check("R10 hold", out_res, last);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      apply_ref(pool_val(), pool_val(), 1'($urandom), 2'($urandom), 2'($urandom));
      if ((i % 97) == 0) begin
        in_vld = 1'b0;
        @(negedge clk);
        check("R10 gap out_vld", {31'h0, out_vld}, 32'h0);
      end
    end

    // R11 mid-run reset
    apply(32'h3F80_0000, 32'h4000_0000, 1, 0, 0, 32'h4000_0000, "R12");
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset out_vld", {31'h0, out_vld}, 32'h0);
    rst = 1'b0; in_vld = 1'b0;
    @(negedge clk);
    check("R11 after reset out_vld", {31'h0, out_vld}, 32'h0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule